// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is one programmable logic element. It combines a lookup table with a parameterised number of inputs (four by default), a storage element, and a dedicated carry path. A serial configuration word sets the cell's behaviour. The word holds the truth table, a choice between the stored and the unstored result, a choice between an edge-triggered flip-flop and a level-sensitive latch, and a carry-mode enable. The word is shifted in on its own configuration clock while the configuration enable is high. Both outputs are held low for as long as loading lasts.

In normal operation the data inputs index the truth table. The result either goes straight to the output or passes through the storage element, which is clocked by the global clock. In carry mode, the two lowest data inputs act as addend bits. The table result is XORed with the incoming carry, and the carry out is the majority of the two addend bits and the carry in. It goes directly to the next cell, so a row of cells forms a ripple adder without using general routing. A synchronous reset clears only the storage element and leaves the configuration unchanged.

Top module: `lut_logic_cell`

## Requirements
- R1: With the direct output selected and carry mode off, `dout` equals truth-table bit number `din`, where `din[0]` is the least significant index bit.
- R2: The configuration word is `CFG_W = 2**LUT_K + 3` bits and is shifted in least significant bit first. Bits `[2**LUT_K-1:0]` are the truth table, the next bit selects the stored output (1), the next selects latch behaviour (1), and the top bit enables carry mode (1).
- R3: In flip-flop mode with the stored output selected, `dout` takes the combinational cell value on each rising `clk` edge and holds it between edges.
- R4: In latch mode with the stored output selected, `dout` follows the combinational value while `clk` is high and holds the value present at the falling edge while `clk` is low.
- R5: In carry mode the combinational value is the table result XOR `cin`, and `cout` is the majority of `din[0]`, `din[1]` and `cin`. With carry mode off, `cout` is 0.
- R6: While `cfg_en` is high, `dout` and `cout` are both 0.
- R7: `rst`, sampled on a rising `clk` edge, clears the storage element and leaves the configuration unchanged.
- R8: `cfg_clk` edges while `cfg_en` is low leave the configuration unchanged.
- R9: Cells chained through `cout` to `cin` and loaded with an XOR table in carry mode produce the binary sum of two operands plus the first carry in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock for the storage element |
| rst | input | 1 | Synchronous active-high clear of the storage element |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Configuration mode; enables shifting and forces the outputs low |
| cfg_sin | input | 1 | Serial configuration data, least significant bit first |
| din | input | LUT_K | Table index inputs; bits 0 and 1 are the addend bits in carry mode |
| cin | input | 1 | Carry from the neighbouring cell |
| dout | output | 1 | Cell logic output |
| cout | output | 1 | Carry to the next cell |

## Verification
The bench builds every cell with the default `LUT_K = 4`. This gives a 19-bit configuration word, so every truth-table entry can be swept exhaustively for several tables, including an asymmetric one that exposes any index-order error. It also builds a chain of four such cells with the same width. The chain reaches full-length carry ripple (all ones plus one), so a carry has to cross every cell before the top carry out settles.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int unsigned MODE_BITS = 3;

    // Mode field sits directly above the truth table; packed MSB first.
    typedef struct packed {
        logic carry_en;
        logic latch_mode;
        logic reg_sel;
    } cell_mode_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/lcell_cfg_shift.sv
module lcell_cfg_shift #(
    parameter int unsigned CFG_W = 19
) (
    input  logic             cfg_clk,
    input  logic             cfg_en,
    input  logic             cfg_sin,
    output logic [CFG_W-1:0] cfg_q
);
    // Enters at the top, so the first bit shifted ends up at bit 0.
    always_ff @(posedge cfg_clk) begin
        if (cfg_en) begin
            cfg_q <= {cfg_sin, cfg_q[CFG_W-1:1]};
        end
    end
endmodule

// File: rtl/lcell_lut_carry.sv
module lcell_lut_carry
    import lcell_pkg::*;
#(
    parameter int unsigned LUT_K = 4,
    localparam int unsigned LUT_BITS = 1 << LUT_K
) (
    input  logic [LUT_BITS-1:0] tbl,
    input  logic [LUT_K-1:0]    din,
    input  logic                cin,
    input  logic                carry_en,
    output logic                comb_val,
    output logic                cout_raw
);
    logic lut_bit;

    always_comb begin
        lut_bit  = tbl[din];
        comb_val = carry_en ? (lut_bit ^ cin) : lut_bit;
        cout_raw = carry_en ? maj3(din[0], din[1], cin) : 1'b0;
    end
endmodule

// File: rtl/lcell_store.sv
module lcell_store (
    input  logic clk,
    input  logic rst,
    input  logic latch_mode,
    input  logic d,
    output logic q
);
    logic q_ff;
    logic q_lat;

    always_ff @(posedge clk) begin
        if (rst) q_ff <= 1'b0;
        else     q_ff <= d;
    end

    // Transparent while clk is high, holds while it is low.
    always_latch begin
        if (clk) begin
            q_lat <= rst ? 1'b0 : d;
        end
    end

    assign q = latch_mode ? q_lat : q_ff;
endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
    import lcell_pkg::*;
#(
    parameter int unsigned LUT_K = 4,
    localparam int unsigned LUT_BITS = 1 << LUT_K,
    localparam int unsigned CFG_W = LUT_BITS + MODE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_clk,
    input  logic             cfg_en,
    input  logic             cfg_sin,
    input  logic [LUT_K-1:0] din,
    input  logic             cin,
    output logic             dout,
    output logic             cout
);
    logic [CFG_W-1:0]    cfg_q;
    logic [LUT_BITS-1:0] tbl;
    cell_mode_t          mode;
    logic                comb_val;
    logic                cout_raw;
    logic                stored;

    lcell_cfg_shift #(.CFG_W(CFG_W)) u_cfg (
        .cfg_clk (cfg_clk),
        .cfg_en  (cfg_en),
        .cfg_sin (cfg_sin),
        .cfg_q   (cfg_q)
    );

    assign tbl  = cfg_q[LUT_BITS-1:0];
    assign mode = cell_mode_t'(cfg_q[CFG_W-1:LUT_BITS]);

    lcell_lut_carry #(.LUT_K(LUT_K)) u_lut (
        .tbl      (tbl),
        .din      (din),
        .cin      (cin),
        .carry_en (mode.carry_en),
        .comb_val (comb_val),
        .cout_raw (cout_raw)
    );

    lcell_store u_store (
        .clk        (clk),
        .rst        (rst),
        .latch_mode (mode.latch_mode),
        .d          (comb_val),
        .q          (stored)
    );

    always_comb begin
        if (cfg_en) begin
            dout = 1'b0;
            cout = 1'b0;
        end else begin
            dout = mode.reg_sel ? stored : comb_val;
            cout = cout_raw;
        end
    end
endmodule

// File: rtl/lcell_checker.sv
module lcell_checker
    import lcell_pkg::*;
#(
    parameter int unsigned CFG_W = 19
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_clk,
    input logic             cfg_en,
    input logic [1:0]       addend,
    input logic             cin,
    input logic             dout,
    input logic             cout,
    input logic [CFG_W-1:0] cfg_q,
    input cell_mode_t       mode,
    input logic             comb_val
);
    // R6
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> (dout == 1'b0 && cout == 1'b0));

    // R3
    ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !$past(cfg_en) && !$past(rst) && mode.reg_sel && !mode.latch_mode)
        |-> (dout == $past(comb_val)));

    // R7
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !cfg_en && mode.reg_sel && !mode.latch_mode) |-> (dout == 1'b0));

    // R5
    carry_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && mode.carry_en) |-> (cout == maj3(addend[0], addend[1], cin)));

    // R8
    cfg_hold_chk: assert property (@(posedge cfg_clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q));
endmodule

bind lut_logic_cell lcell_checker #(.CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_clk  (cfg_clk),
    .cfg_en   (cfg_en),
    .addend   (din[1:0]),
    .cin      (cin),
    .dout     (dout),
    .cout     (cout),
    .cfg_q    (cfg_q),
    .mode     (mode),
    .comb_val (comb_val)
);

// File: tb/test_lut_logic_cell.sv
module test_lut_logic_cell;
    localparam int K  = 4;
    localparam int TB = 1 << K;
    localparam int CW = TB + 3;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_clk = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_sin = 1'b0;
    logic [K-1:0] din = '0;
    logic cin = 1'b0;
    logic dout, cout;

    logic [NCH-1:0] ch_a = '0, ch_b = '0, ch_sum;
    logic [NCH:0]   ch_c;
    logic           ch_cin = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lut_logic_cell #(.LUT_K(K)) i_lut_logic_cell (
        .clk(clk), .rst(rst), .cfg_clk(cfg_clk), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
        .din(din), .cin(cin), .dout(dout), .cout(cout)
    );

    assign ch_c[0] = ch_cin;
    for (genvar g = 0; g < NCH; g++) begin : g_chain
        lut_logic_cell #(.LUT_K(K)) u_cell (
            .clk(clk), .rst(rst), .cfg_clk(cfg_clk), .cfg_en(cfg_en), .cfg_sin(cfg_sin),
            .din({2'b00, ch_b[g], ch_a[g]}), .cin(ch_c[g]), .dout(ch_sum[g]), .cout(ch_c[g+1])
        );
    end

    function automatic logic [CW-1:0] mk_cfg(input logic [TB-1:0] t, input logic rs,
                                             input logic lm, input logic ce);
        return {ce, lm, rs, t};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R2: word bit 0 is shifted first
    task automatic load(input logic [CW-1:0] w);
        cfg_en = 1'b1;
        for (int k = 0; k < CW; k++) begin
            cfg_sin = w[k];
            #5 cfg_clk = 1'b1;
            #5 cfg_clk = 1'b0;
        end
        cfg_en = 1'b0;
        #1;
    endtask

    task automatic t_lut_comb();
        logic [TB-1:0] tabs [3];
        tabs[0] = 16'h0001; tabs[1] = 16'h6996; tabs[2] = 16'hA5C3;
        for (int i = 0; i < 3; i++) begin
            load(mk_cfg(tabs[i], 1'b0, 1'b0, 1'b0));
            for (int d = 0; d < TB; d++) begin
                din = K'(d);
                #2 chk(dout == tabs[i][d], "R1/R2 table lookup", dout, tabs[i][d]);
            end
        end
    endtask

    task automatic t_quiet();
        load(mk_cfg(16'hFFFF, 1'b0, 1'b0, 1'b1));
        din = 4'h3; cin = 1'b1;
        #2 chk(dout == 1'b0 && cout == 1'b1, "R5 pre-config values", {dout, cout}, 2'b01);
        cfg_en = 1'b1;
        #2 chk(dout == 1'b0 && cout == 1'b0, "R6 outputs low in config", {dout, cout}, 0);
        for (int k = 0; k < 3; k++) begin
            cfg_sin = 1'b1;
            #5 cfg_clk = 1'b1;
            #5 cfg_clk = 1'b0;
        end
        #2 chk(dout == 1'b0 && cout == 1'b0, "R6 outputs low mid-load", {dout, cout}, 0);
        load(mk_cfg(16'hFFFF, 1'b0, 1'b0, 1'b0));
        cin = 1'b0;
    endtask

    task automatic t_ff();
        logic [TB-1:0] t = 16'hA5C3;
        logic prev;
        logic [3:0] seq [6];
        seq[0] = 4'h0; seq[1] = 4'h1; seq[2] = 4'h2; seq[3] = 4'h7; seq[4] = 4'hF; seq[5] = 4'h8;
        load(mk_cfg(t, 1'b1, 1'b0, 1'b0));
        @(negedge clk); din = 4'h3;
        @(posedge clk); #2 prev = t[3];
        chk(dout == prev, "R3 first capture", dout, prev);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); din = seq[i];
            #2 chk(dout == prev, "R3 hold between edges", dout, prev);
            @(posedge clk); #2 chk(dout == t[seq[i]], "R3 capture at edge", dout, t[seq[i]]);
            prev = t[seq[i]];
        end
    endtask

    task automatic t_latch();
        logic [TB-1:0] t = 16'h6996;
        load(mk_cfg(t, 1'b1, 1'b1, 1'b0));
        @(posedge clk); #2 din = 4'h1;
        #1 chk(dout == t[1], "R4 transparent high", dout, t[1]);
        din = 4'h3;
        #1 chk(dout == t[3], "R4 transparent follow", dout, t[3]);
        din = 4'h7;
        #1 chk(dout == t[7], "R4 transparent follow 2", dout, t[7]);
        @(negedge clk); #2 din = 4'h6;
        #1 chk(dout == t[7], "R4 hold while low", dout, t[7]);
        din = 4'h0;
        #1 chk(dout == t[7], "R4 hold while low 2", dout, t[7]);
        @(posedge clk); #2 chk(dout == t[0], "R4 reopens high", dout, t[0]);
    endtask

    task automatic t_carry();
        logic e_s, e_c;
        load(mk_cfg(16'h6666, 1'b0, 1'b0, 1'b1));
        for (int v = 0; v < 8; v++) begin
            din = {2'b10, v[1], v[0]};
            cin = v[2];
            e_s = v[0] ^ v[1] ^ v[2];
            e_c = (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
            #2 chk(dout == e_s, "R5 carry-mode sum", dout, e_s);
            chk(cout == e_c, "R5 carry-mode carry out", cout, e_c);
        end
        load(mk_cfg(16'h6666, 1'b0, 1'b0, 1'b0));
        din = 4'h3; cin = 1'b1;
        #2 chk(cout == 1'b0, "R5 carry off gives zero cout", cout, 0);
        chk(dout == 1'b0, "R5 carry off ignores cin", dout, 0);
        cin = 1'b0;
    endtask

    task automatic t_reset();
        load(mk_cfg(16'h8000, 1'b1, 1'b0, 1'b0));
        @(negedge clk); din = 4'hF;
        @(posedge clk); #2 chk(dout == 1'b1, "R7 captured before reset", dout, 1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2 chk(dout == 1'b0, "R7 reset clears store", dout, 0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2 chk(dout == 1'b1, "R7 config kept across reset", dout, 1);
    endtask

    task automatic t_cfg_ignore();
        logic [TB-1:0] t = 16'h00FF;
        load(mk_cfg(t, 1'b0, 1'b0, 1'b0));
        for (int k = 0; k < CW; k++) begin
            cfg_sin = k[0];
            #5 cfg_clk = 1'b1;
            #5 cfg_clk = 1'b0;
        end
        for (int d = 0; d < TB; d++) begin
            din = K'(d);
            #2 chk(dout == t[d], "R8 shift ignored when disabled", dout, t[d]);
        end
    endtask

    task automatic t_chain();
        logic [11:0] vec [6];
        logic [NCH:0] exp;
        vec[0] = {4'hF, 4'h1, 4'h0}; vec[1] = {4'h0, 4'h0, 4'h1};
        vec[2] = {4'hA, 4'h5, 4'h1}; vec[3] = {4'h7, 4'h8, 4'h0};
        vec[4] = {4'hF, 4'hF, 4'h1}; vec[5] = {4'h3, 4'hC, 4'h0};
        load(mk_cfg(16'h6666, 1'b0, 1'b0, 1'b1));
        for (int i = 0; i < 6; i++) begin
            ch_a = vec[i][11:8]; ch_b = vec[i][7:4]; ch_cin = vec[i][0];
            exp = ch_a + ch_b + ch_cin;
            #2 chk({ch_c[NCH], ch_sum} == exp, "R9 ripple chain sum", {ch_c[NCH], ch_sum}, exp);
        end
    endtask

    initial begin
        load(mk_cfg(16'h0000, 1'b1, 1'b0, 1'b0));
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #2 chk(dout == 1'b0 && cout == 1'b0, "R7 reset state", {dout, cout}, 0);
        t_quiet();
        t_lut_comb();
        t_ff();
        t_latch();
        t_carry();
        t_reset();
        t_cfg_ignore();
        t_chain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule